// File: doc/BRIEF.md
# Multi-Mode Timer Register Bank

This block is the software-visible register file of a 24-bit timer that can run as an interval timer, a pulse generator or a watchdog. A simple byte-addressed bus reaches it through read and write strobes, an address, 32-bit write data and four byte enables. Each register keeps only its implemented bits, and each byte lane is written only when its enable is high. The decoded window is 256 bytes. Word offsets the core relies on are fixed: control 0x00, status 0x04, compare A 0x08, compare B 0x0C, interval mode 0x10, divider 0x20, pulse mode 0x30, watchdog mode 0x40 and live count 0xF0.

The counter core reads the decoded fields from dedicated outputs and returns its live count and one-cycle status-set pulses. The bank sends the core three one-cycle commands. The first clears the counter when a control write stops the timer while clear is enabled. The second tells the interrupt logic to drop its request when a status write removes pending flags. The third presets the output flip-flop during reset.

Top module: `tmr_reg_bank`

## Requirements
- R1: Synchronous reset clears control, status, divider and the three mode registers to zero and sets both compare registers to 0x00FFFFFF; rdata reads zero after reset.
- R2: A write to offset 0x00 with byte enable 0 stores wdata[7:0] masked with 0xEF. Bit 7 is count enable, bit 6 divider enable, bit 5 clear enable, bit 2 clock select and bits 1:0 the mode. Without byte enable 0 the register is unchanged.
- R3: cnt_clear pulses for exactly one cycle, the cycle after a byte-0 control write whose data has bit 7 = 0 and bit 5 = 1, and at no other time.
- R4: A write to offset 0x04 with byte enable 0 clears every status flag, whatever the data. irq_clear pulses the next cycle only if at least one flag was set before the write.
- R5: A stat_set bit sets its status flag on the next edge (bit 3 watchdog, bit 2 pulse B, bit 1 pulse A, bit 0 interval). A set in the same cycle as a clearing write wins.
- R6: Compare A (0x08) and compare B (0x0C) keep 24 bits written through byte lanes 0 to 2. Lane 3 is ignored and reads as zero.
- R7: Each mode register keeps only the bits named here, each written through its own lane. Interval mode (0x10) keeps bit 15 as interrupt enable and bit 0 as zero-clear. Pulse mode (0x30) keeps bit 15 as B enable, bit 14 as A enable and bit 0 as the flip-flop initial value. Watchdog mode (0x40) keeps bit 15 as interrupt enable, bit 7 as disable and bit 0 as clear.
- R8: The divider register (0x20) keeps only bits 2:0, written through lane 0.
- R9: A read returns the full 32-bit word on rdata one cycle after rd_en, whatever the byte enables. Offset 0xF0 returns count_in zero-extended. Unimplemented offsets return zero. rdata holds its value while rd_en is low.
- R10: Writes to 0xF0 and to unimplemented offsets change nothing. Write data never sets status bits, and a status write without byte enable 0 has no effect.
- R11: While reset is held, ff_load is high. ff_load_val carries the flip-flop initial value that was stored before reset began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address inside the window |
| be | input | 4 | Write byte enables, lane 0 least significant |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| count_in | input | 24 | Live count from the counter core |
| stat_set | input | 4 | Status-set pulses from the core |
| ctl_count_en | output | 1 | Count enable |
| ctl_div_en | output | 1 | Divider enable |
| ctl_clr_en | output | 1 | Counter clear enable |
| ctl_clk_sel | output | 1 | Clock source select |
| ctl_mode | output | 2 | Timer mode |
| div_sel | output | 3 | Divider select |
| cmp_a | output | 24 | Compare A value |
| cmp_b | output | 24 | Compare B value |
| iv_irq_en | output | 1 | Interval interrupt enable |
| iv_zero_clr | output | 1 | Interval zero-clear enable |
| pg_irq_a_en | output | 1 | Pulse A interrupt enable |
| pg_irq_b_en | output | 1 | Pulse B interrupt enable |
| pg_ff_init | output | 1 | Flip-flop initial value |
| wd_irq_en | output | 1 | Watchdog interrupt enable |
| wd_disable | output | 1 | Watchdog disable |
| wd_clear | output | 1 | Watchdog clear |
| status | output | 4 | Pending status flags |
| cnt_clear | output | 1 | One-cycle counter clear command |
| irq_clear | output | 1 | One-cycle interrupt withdraw command |
| ff_load | output | 1 | Flip-flop preset strobe during reset |
| ff_load_val | output | 1 | Flip-flop preset value |

## Verification
Two cases are the hardest to reach. The first is a clearing status write that lands in the same cycle as a status-set pulse, where the new flag must survive and irq_clear must still follow the old flags. The second is the flip-flop preset, which needs a pulse-mode write before a reset that lasts several cycles, so that the captured value must not be replaced by the already-cleared register. The stimulus runs both cases as directed sequences. It then runs a long random phase that mixes set pulses, status writes, partial byte enables and reads, all compared cycle by cycle against a behavioural model.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int DATA_W = 32;
  // word indices (byte offset / 4)
  localparam int IDX_CTL   = 'h00;
  localparam int IDX_STAT  = 'h01;
  localparam int IDX_CMPA  = 'h02;
  localparam int IDX_CMPB  = 'h03;
  localparam int IDX_IVAL  = 'h04;
  localparam int IDX_DIV   = 'h08;
  localparam int IDX_PULSE = 'h0C;
  localparam int IDX_WDOG  = 'h10;
  localparam int IDX_COUNT = 'h3C;
  // implemented-bit masks
  localparam logic [DATA_W-1:0] MASK_CTL   = 32'h0000_00EF;
  localparam logic [DATA_W-1:0] MASK_IVAL  = 32'h0000_8001;
  localparam logic [DATA_W-1:0] MASK_DIV   = 32'h0000_0007;
  localparam logic [DATA_W-1:0] MASK_PULSE = 32'h0000_C001;
  localparam logic [DATA_W-1:0] MASK_WDOG  = 32'h0000_8081;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK    = '1,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [7:0] LM = MASK[g*8 +: 8];
    localparam logic [7:0] LR = RST_VAL[g*8 +: 8] & LM;
    if (LM == 8'h00) begin : g_const
      logic unused_lane;
      assign unused_lane = be[g] ^ (^wdata[g*8 +: 8]);
      assign q[g*8 +: 8] = 8'h00;
    end else begin : g_flop
      logic [7:0] r;
      always_ff @(posedge clk) begin
        if (rst)                r <= LR;
        else if (wr && be[g])   r <= wdata[g*8 +: 8] & LM;
      end
      assign q[g*8 +: 8] = r;
    end
  end
endmodule

// File: rtl/tmr_status_reg.sv
module tmr_status_reg #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NFLAG-1:0] set,
  output logic [NFLAG-1:0] flags,
  output logic             clr_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      clr_hit <= 1'b0;
    end else begin
      clr_hit <= clr && (flags != '0);
      flags   <= (clr ? '0 : flags) | set;
    end
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!clr && set == '0) |=> $stable(flags));
  assert_hit_after_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_hit |-> $past(clr));
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_regs_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 24,
  parameter int NFLAG = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] ctl_q,
  input  logic [NFLAG-1:0]  stat_q,
  input  logic [DATA_W-1:0] cmpa_q,
  input  logic [DATA_W-1:0] cmpb_q,
  input  logic [DATA_W-1:0] ival_q,
  input  logic [DATA_W-1:0] div_q,
  input  logic [DATA_W-1:0] pulse_q,
  input  logic [DATA_W-1:0] wdog_q,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    case (idx)
      IDX_W'(IDX_CTL):   word = ctl_q;
      IDX_W'(IDX_STAT):  word = DATA_W'(stat_q);
      IDX_W'(IDX_CMPA):  word = cmpa_q;
      IDX_W'(IDX_CMPB):  word = cmpb_q;
      IDX_W'(IDX_IVAL):  word = ival_q;
      IDX_W'(IDX_DIV):   word = div_q;
      IDX_W'(IDX_PULSE): word = pulse_q;
      IDX_W'(IDX_WDOG):  word = wdog_q;
      IDX_W'(IDX_COUNT): word = DATA_W'(count);
      default:           word = '0;
    endcase
  end
endmodule

// File: rtl/tmr_reg_bank.sv
module tmr_reg_bank
  import tmr_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int NFLAG  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [NFLAG-1:0]  stat_set,
  output logic              ctl_count_en,
  output logic              ctl_div_en,
  output logic              ctl_clr_en,
  output logic              ctl_clk_sel,
  output logic [1:0]        ctl_mode,
  output logic [2:0]        div_sel,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output logic              iv_irq_en,
  output logic              iv_zero_clr,
  output logic              pg_irq_a_en,
  output logic              pg_irq_b_en,
  output logic              pg_ff_init,
  output logic              wd_irq_en,
  output logic              wd_disable,
  output logic              wd_clear,
  output logic [NFLAG-1:0]  status,
  output logic              cnt_clear,
  output logic              irq_clear,
  output logic              ff_load,
  output logic              ff_load_val
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] CMP_MASK = DATA_W'((64'd1 << CNT_W) - 1);

  logic [IDX_W-1:0] idx;
  logic unused_lsb;
  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  logic wr_ctl, wr_stat, wr_cmpa, wr_cmpb, wr_ival, wr_div, wr_pulse, wr_wdog;
  assign wr_ctl   = wr_en && idx == IDX_W'(IDX_CTL);
  assign wr_stat  = wr_en && idx == IDX_W'(IDX_STAT);
  assign wr_cmpa  = wr_en && idx == IDX_W'(IDX_CMPA);
  assign wr_cmpb  = wr_en && idx == IDX_W'(IDX_CMPB);
  assign wr_ival  = wr_en && idx == IDX_W'(IDX_IVAL);
  assign wr_div   = wr_en && idx == IDX_W'(IDX_DIV);
  assign wr_pulse = wr_en && idx == IDX_W'(IDX_PULSE);
  assign wr_wdog  = wr_en && idx == IDX_W'(IDX_WDOG);

  logic [DATA_W-1:0] ctl_q, cmpa_q, cmpb_q, ival_q, div_q, pulse_q, wdog_q;

  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(MASK_CTL), .RST_VAL('0)) u_ctl (
    .clk(clk), .rst(rst), .wr(wr_ctl), .be(be), .wdata(wdata), .q(ctl_q));
  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(CMP_MASK), .RST_VAL(CMP_MASK)) u_cmpa (
    .clk(clk), .rst(rst), .wr(wr_cmpa), .be(be), .wdata(wdata), .q(cmpa_q));
  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(CMP_MASK), .RST_VAL(CMP_MASK)) u_cmpb (
    .clk(clk), .rst(rst), .wr(wr_cmpb), .be(be), .wdata(wdata), .q(cmpb_q));
  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(MASK_IVAL), .RST_VAL('0)) u_ival (
    .clk(clk), .rst(rst), .wr(wr_ival), .be(be), .wdata(wdata), .q(ival_q));
  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(MASK_DIV), .RST_VAL('0)) u_div (
    .clk(clk), .rst(rst), .wr(wr_div), .be(be), .wdata(wdata), .q(div_q));
  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(MASK_PULSE), .RST_VAL('0)) u_pulse (
    .clk(clk), .rst(rst), .wr(wr_pulse), .be(be), .wdata(wdata), .q(pulse_q));
  tmr_cfg_reg #(.DATA_W(DATA_W), .MASK(MASK_WDOG), .RST_VAL('0)) u_wdog (
    .clk(clk), .rst(rst), .wr(wr_wdog), .be(be), .wdata(wdata), .q(wdog_q));

  tmr_status_reg #(.NFLAG(NFLAG)) u_stat (
    .clk(clk), .rst(rst), .clr(wr_stat && be[0]), .set(stat_set),
    .flags(status), .clr_hit(irq_clear));

  logic [DATA_W-1:0] rd_word;
  tmr_read_mux #(.IDX_W(IDX_W), .CNT_W(CNT_W), .NFLAG(NFLAG)) u_rmux (
    .idx(idx), .ctl_q(ctl_q), .stat_q(status), .cmpa_q(cmpa_q), .cmpb_q(cmpb_q),
    .ival_q(ival_q), .div_q(div_q), .pulse_q(pulse_q), .wdog_q(wdog_q),
    .count(count_in), .word(rd_word));

  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      rdata       <= '0;
      cnt_clear   <= 1'b0;
      ff_load     <= 1'b1;
      ff_load_val <= rst_q ? ff_load_val : pulse_q[0];
    end else begin
      ff_load   <= 1'b0;
      cnt_clear <= wr_ctl && be[0] && !wdata[7] && wdata[5];
      if (rd_en) rdata <= rd_word;
    end
  end

  assign ctl_count_en = ctl_q[7];
  assign ctl_div_en   = ctl_q[6];
  assign ctl_clr_en   = ctl_q[5];
  assign ctl_clk_sel  = ctl_q[2];
  assign ctl_mode     = ctl_q[1:0];
  assign div_sel      = div_q[2:0];
  assign cmp_a        = cmpa_q[CNT_W-1:0];
  assign cmp_b        = cmpb_q[CNT_W-1:0];
  assign iv_irq_en    = ival_q[15];
  assign iv_zero_clr  = ival_q[0];
  assign pg_irq_b_en  = pulse_q[15];
  assign pg_irq_a_en  = pulse_q[14];
  assign pg_ff_init   = pulse_q[0];
  assign wd_irq_en    = wdog_q[15];
  assign wd_disable   = wdog_q[7];
  assign wd_clear     = wdog_q[0];

  assert_clear_cause_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |-> $past(wr_en && be[0] && !wdata[7] && wdata[5]));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  assert_status_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && be[0] && stat_set == '0) |=> (status == '0));
  assert_stat_not_written_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !be[0] && stat_set == '0) |=> $stable(status));
endmodule

// File: tb/tmr_reg_bank_bench.sv
module tmr_reg_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [23:0] count_in = 24'h123456;
  logic [3:0] stat_set = '0;
  logic ctl_count_en, ctl_div_en, ctl_clr_en, ctl_clk_sel;
  logic [1:0] ctl_mode;
  logic [2:0] div_sel;
  logic [23:0] cmp_a, cmp_b;
  logic iv_irq_en, iv_zero_clr, pg_irq_a_en, pg_irq_b_en, pg_ff_init;
  logic wd_irq_en, wd_disable, wd_clear;
  logic [3:0] status;
  logic cnt_clear, irq_clear, ff_load, ff_load_val;

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_reg_bank u_tmr_reg_bank (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .count_in(count_in), .stat_set(stat_set),
    .ctl_count_en(ctl_count_en), .ctl_div_en(ctl_div_en), .ctl_clr_en(ctl_clr_en),
    .ctl_clk_sel(ctl_clk_sel), .ctl_mode(ctl_mode), .div_sel(div_sel),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .iv_irq_en(iv_irq_en), .iv_zero_clr(iv_zero_clr),
    .pg_irq_a_en(pg_irq_a_en), .pg_irq_b_en(pg_irq_b_en), .pg_ff_init(pg_ff_init),
    .wd_irq_en(wd_irq_en), .wd_disable(wd_disable), .wd_clear(wd_clear),
    .status(status), .cnt_clear(cnt_clear), .irq_clear(irq_clear),
    .ff_load(ff_load), .ff_load_val(ff_load_val));

  // behavioural reference state
  logic [31:0] m_ctl, m_ival, m_div, m_pul, m_wdg, m_cmpa, m_cmpb, m_rd;
  logic [3:0] m_stat;
  logic m_cclr, m_iclr, m_ffl, m_ffv, m_rstq;
  initial begin
    m_ctl = 0; m_ival = 0; m_div = 0; m_pul = 0; m_wdg = 0; m_rd = 0;
    m_cmpa = 32'hFFFFFF; m_cmpb = 32'hFFFFFF; m_stat = 0;
    m_cclr = 0; m_iclr = 0; m_ffl = 0; m_ffv = 0; m_rstq = 0;
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] keep,
                                        logic [31:0] d, logic [3:0] en);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (en[b])
        for (int i = 0; i < 8; i++)
          if (keep[b*8+i]) r[b*8+i] = d[b*8+i];
    return r;
  endfunction

  function automatic logic [31:0] mread(int w);
    case (w)
      0: return m_ctl;  1: return {28'd0, m_stat};
      2: return m_cmpa; 3: return m_cmpb;
      4: return m_ival; 8: return m_div;
      12: return m_pul; 16: return m_wdg;
      60: return {8'd0, count_in};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ffv = m_rstq ? m_ffv : m_pul[0];
      m_ffl = 1; m_rstq = 1;
      m_ctl = 0; m_ival = 0; m_div = 0; m_pul = 0; m_wdg = 0; m_stat = 0; m_rd = 0;
      m_cmpa = 32'hFFFFFF; m_cmpb = 32'hFFFFFF; m_cclr = 0; m_iclr = 0;
    end else begin
      int widx;
      m_rstq = 0; m_ffl = 0;
      if (rd_en) m_rd = mread(int'(addr >> 2));
      widx = wr_en ? int'(addr >> 2) : -1;
      m_cclr = (widx == 0) && be[0] && !wdata[7] && wdata[5];
      m_iclr = (widx == 1) && be[0] && (m_stat != 0);
      m_stat = (((widx == 1) && be[0]) ? 4'd0 : m_stat) | stat_set;
      case (widx)
        0:  m_ctl  = merge(m_ctl,  32'h0000_00EF, wdata, be);
        2:  m_cmpa = merge(m_cmpa, 32'h00FF_FFFF, wdata, be);
        3:  m_cmpb = merge(m_cmpb, 32'h00FF_FFFF, wdata, be);
        4:  m_ival = merge(m_ival, 32'h0000_8001, wdata, be);
        8:  m_div  = merge(m_div,  32'h0000_0007, wdata, be);
        12: m_pul  = merge(m_pul,  32'h0000_C001, wdata, be);
        16: m_wdg  = merge(m_wdg,  32'h0000_8081, wdata, be);
        default: ;
      endcase
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (armed) begin
    chk("R2 control", {ctl_count_en, ctl_div_en, ctl_clr_en, ctl_clk_sel, ctl_mode},
        {m_ctl[7], m_ctl[6], m_ctl[5], m_ctl[2], m_ctl[1:0]});
    chk("R6 compare", {cmp_a, cmp_b}, {m_cmpa[23:0], m_cmpb[23:0]});
    chk("R7 modes", {iv_irq_en, iv_zero_clr, pg_irq_b_en, pg_irq_a_en, pg_ff_init,
        wd_irq_en, wd_disable, wd_clear},
        {m_ival[15], m_ival[0], m_pul[15], m_pul[14], m_pul[0], m_wdg[15], m_wdg[7], m_wdg[0]});
    chk("R8 divider", div_sel, m_div[2:0]);
    chk("R5 status", status, m_stat);
    chk("R3 cnt_clear", cnt_clear, m_cclr);
    chk("R4 irq_clear", irq_clear, m_iclr);
    chk("R9 rdata", rdata, m_rd);
    chk("R11 ff_load", ff_load, m_ffl);
    if (ff_load) chk("R11 ff_load_val", ff_load_val, m_ffv);
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d, logic [3:0] e);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; be = e;
    @(negedge clk); wr_en = 0; be = 0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; be = 4'h0;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic do_reset(int n);
    @(negedge clk); rst = 1;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] alist [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h40, 8'hF0, 8'h14, 8'h50};

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0; armed = 1;
    // R1: reset values
    bus_read(8'h08, v); chk("R1 cmp_a reset", v, 32'h00FFFFFF);
    bus_read(8'h00, v); chk("R1 ctl reset", v, 0);
    bus_read(8'h04, v); chk("R1 status reset", v, 0);
    bus_read(8'h50, v); chk("R9 unimplemented", v, 0);
    // R2 masking and lane gating
    bus_write(8'h00, 32'hFFFF_FFFF, 4'h1);
    bus_read(8'h00, v); chk("R2 ctl mask", v, 32'hEF);
    bus_write(8'h00, 32'h0000_0000, 4'hE);
    bus_read(8'h00, v); chk("R2 no lane0", v, 32'hEF);
    // R3: stop with clear enabled, then run with clear enabled
    bus_write(8'h00, 32'h20, 4'h1);
    bus_write(8'h00, 32'hA0, 4'h1);
    // R6 compare lanes
    bus_write(8'h08, 32'hAABB_CCDD, 4'hF);
    bus_read(8'h08, v); chk("R6 cmp_a lane3", v, 32'h00BBCCDD);
    bus_write(8'h0C, 32'h1122_3344, 4'h2);
    bus_read(8'h0C, v); chk("R6 cmp_b one lane", v, 32'h00FF33FF);
    // R7 / R8
    bus_write(8'h10, 32'hFFFF_FFFF, 4'h2);
    bus_write(8'h30, 32'hFFFF_FFFF, 4'hF);
    bus_write(8'h40, 32'hFFFF_FFFF, 4'h1);
    bus_write(8'h20, 32'hFFFF_FFFF, 4'hF);
    bus_read(8'h30, v); chk("R7 pulse", v, 32'hC001);
    bus_read(8'h40, v); chk("R7 watchdog", v, 32'h0081);
    bus_read(8'h20, v); chk("R8 divider", v, 32'h7);
    // R5 / R4 status
    @(negedge clk); stat_set = 4'h5;
    @(negedge clk); stat_set = 4'h0;
    bus_write(8'h04, 32'hFFFF_FFFF, 4'h2);   // R10: no lane 0, no effect
    chk("R10 status kept", status, 4'h5);
    bus_write(8'h04, 32'h0, 4'h1);
    bus_write(8'h04, 32'h0, 4'h1);           // nothing pending: no irq_clear
    @(negedge clk); stat_set = 4'h8; wr_en = 1; addr = 8'h04; be = 4'h1;
    @(negedge clk); stat_set = 0; wr_en = 0; be = 0;
    chk("R5 set beats clear", status, 4'h8);
    // R10 count offset write ignored
    bus_write(8'hF0, 32'hFFFF_FFFF, 4'hF);
    bus_read(8'hF0, v); chk("R9 count read", v, 32'h00123456);
    // R11 preset from the initial-value bit held before reset
    bus_write(8'h30, 32'h1, 4'h1);
    do_reset(3);
    chk("R11 ff_load", ff_load, 1'b1);
    chk("R11 ff_load_val", ff_load_val, 1'b1);
    rst = 0;
    // random phase
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      rd_en = ($urandom % 3) == 0;
      wr_en = ($urandom % 2) == 0;
      addr = alist[$urandom % 11];
      be = 4'($urandom);
      wdata = $urandom;
      stat_set = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      count_in = 24'($urandom);
    end
    @(negedge clk); rd_en = 0; wr_en = 0; stat_set = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule